// File: doc/BRIEF.md
# SPI Target Controller with Mirrored FIFOs

This block is the receive and transmit datapath of a SPI target (slave). One byte-wide storage array is split into two equal halves. The lower half is a receive FIFO that the serial side fills. The upper half is a transmit FIFO that the serial side drains. On each FIFO, one pointer moves in hardware and the other is set by software. All four pointers carry one extra wrap bit above the address bits, so a full FIFO and an empty FIFO can be told apart without a separate count.

The serial pins are sampled by the system clock through synchronizers. The block supports all four clock polarity and phase combinations, shifting most significant bit first. When the transmit FIFO has no data, the target sends a programmable filler byte. When chip select is released, unsent transmit bytes are discarded. A level interrupt tells software that the receive FIFO holds more bytes than a run-time threshold.

Software reaches the block through a word-wide register bus. The bus holds the control, threshold, pointer and status registers, and a window onto the storage array. With `AW` address bits per FIFO, the bus address is `AW+2` bits wide:
- Address bit `AW+1` set selects the storage window. Bit `AW` then picks the half: 0 for receive, 1 for transmit.
- Address bit `AW+1` clear selects the registers, at word offsets 0x00 to 0x18.

Top module: `spi_target_fifo`

## Requirements
- R1: After reset:
  - the control word reads 0x0000FF00 (mode 0, filler byte 0xFF);
  - the threshold at offset 0x04 reads 8;
  - every pointer reads 0;
  - status at offset 0x18 reads 0;
  - `rx_irq` is low.
- R2: Each completed received byte is stored at the receive write pointer, and that pointer advances by one. Software can read the pointer at offset 0x0C. In a bus word, byte k occupies bits 8k+7..8k.
- R3: If the receive FIFO is full when a byte completes, the byte is dropped and the receive write pointer holds. Status bit 1 is set, and it stays set until software writes 1 to that bit.
- R4: `rx_irq` and status bit 0 are high exactly when the receive fill level exceeds the threshold. With the default of 8, the ninth byte raises the interrupt. The threshold can be rewritten at any time and takes effect at once.
- R5: Bytes placed in the transmit FIFO are shifted out on MISO in FIFO order, most significant bit first, and the transmit read pointer (offset 0x14) advances by one per byte.
- R6: While the transmit FIFO is empty, the target sends the filler byte held in control bits 15..8.
- R7: When chip select deasserts, the transmit read pointer is set equal to the transmit write pointer. Leftover bytes are therefore never sent in a later transaction.
- R8: Pointers are AW+1 bits wide and wrap at twice the FIFO depth. A FIFO is empty when both pointers are equal. It is full when their low AW bits match and their top bits differ. Bytes stored past the end of the array wrap to its start.
- R9: A bus write into the storage window takes effect only when all four byte enables are set. Only the transmit half can be written from the bus. Any part of the window can be read.
- R10: Control bit 0 selects the SCLK idle level and bit 1 selects the phase:
  - with phase 0, data is sampled on the first edge after idle;
  - with phase 1, data is sampled on the second edge.
  All four combinations transfer data correctly in both directions.
- R11: A byte left incomplete when chip select deasserts is discarded. The next transaction starts again at bit 7.
- R12: A software write of the receive read pointer (offset 0x08) frees space at once and lowers the fill level that the interrupt compares.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the controller |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial data to the controller |
| bus_addr | input | AW+2 | Byte address of the register or storage word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_be | input | 4 | Byte enables for a write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| rx_irq | output | 1 | Receive fill level above threshold |

## Verification
The bench builds the block with `AW=4`, which gives 16-byte FIFOs and 32-step pointers. With this setting, filling the receive FIFO to full, forcing an overflow and wrapping both transmit and receive pointers through the wrap bit all take a few dozen serial bytes. The threshold keeps its default of 8, so the nine-byte interrupt boundary is tested as specified. The serial half period is eight system clocks, which leaves room for the synchronizer latency in every mode.

// File: rtl/spit_pkg.sv
package spit_pkg;

  // Register word index, taken from bus address bits [4:2].
  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_THRESH = 3'd1,
    SEL_RXRD   = 3'd2,
    SEL_RXWR   = 3'd3,
    SEL_TXWR   = 3'd4,
    SEL_TXRD   = 3'd5,
    SEL_STAT   = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic [7:0] idle;
    logic       cpha;
    logic       cpol;
  } spi_cfg_t;

  function automatic logic [7:0] lane_of(input logic [31:0] w, input int k);
    return w[8*k +: 8];
  endfunction

endpackage

// File: rtl/spit_sync.sv
module spit_sync #(
  parameter int           W      = 3,
  parameter int           STAGES = 2,
  parameter logic [W-1:0] INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= {STAGES{INIT}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spit_ptrs.sv
module spit_ptrs #(
  parameter int AW        = 10,
  parameter bit HW_WRITES = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_adv,
  input  logic        sw_load,
  input  logic [AW:0] sw_val,
  input  logic        flush,
  output logic [AW:0] wr_ptr,
  output logic [AW:0] rd_ptr,
  output logic        empty,
  output logic        full,
  output logic [AW:0] level
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = {1'b1, {AW{1'b0}}};

  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return w - r;
  endfunction

  function automatic logic wrapped_equal(input logic [PW-1:0] w, input logic [PW-1:0] r);
    return (w[AW-1:0] == r[AW-1:0]) && (w[AW] != r[AW]);
  endfunction

  logic [PW-1:0] hw_q, sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hw_q <= '0;
    else if (flush)  hw_q <= sw_q;
    else if (hw_adv) hw_q <= hw_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sw_q <= '0;
    else if (sw_load) sw_q <= sw_val;
  end

  generate
    if (HW_WRITES) begin : g_writer
      assign wr_ptr = hw_q;
      assign rd_ptr = sw_q;
      a_r3_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        hw_adv |-> !full);
    end else begin : g_reader
      assign wr_ptr = sw_q;
      assign rd_ptr = hw_q;
      a_r5_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        hw_adv |-> !empty);
      a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !sw_load) |=> empty);
    end
  endgenerate

  assign empty = (wr_ptr == rd_ptr);
  assign full  = wrapped_equal(wr_ptr, rd_ptr);
  assign level = fill_of(wr_ptr, rd_ptr);

  a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH);
  a_r8_full_is_depth: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (level == DEPTH));
endmodule

// File: rtl/spit_engine.sv
module spit_engine #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  input  logic       cpol,
  input  logic       cpha,
  input  logic [7:0] tx_byte,
  output logic       tx_take,
  output logic       rx_done,
  output logic [7:0] rx_data,
  output logic       cs_stop,
  output logic       miso
);
  logic [2:0] sync_q;
  logic       sclk_s, csn_s, mosi_s;

  spit_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk_i, cs_n_i, mosi_i}),
    .q    (sync_q)
  );
  assign {sclk_s, csn_s, mosi_s} = sync_q;

  logic sclk_d, act_d;
  logic active, rise, fall, lead, trail;
  logic sample_edge, shift_edge, cs_start;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      act_d  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      act_d  <= active;
    end
  end

  assign active      = !csn_s;
  assign rise        = sclk_s & ~sclk_d;
  assign fall        = ~sclk_s & sclk_d;
  assign lead        = cpol ? fall : rise;
  assign trail       = cpol ? rise : fall;
  assign sample_edge = active & (cpha ? trail : lead);
  assign shift_edge  = active & (cpha ? lead : trail);
  assign cs_start    = active & ~act_d;
  assign cs_stop     = ~active & act_d;

  // A byte boundary is reached when the bit counter is back at zero.
  assign tx_take = (cs_start & ~cpha) | (shift_edge & (bit_cnt == 3'd0));
  assign rx_done = sample_edge & (bit_cnt == 3'd7);
  assign rx_data = {rx_sh, mosi_s};
  assign miso    = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else if (!active) begin
      bit_cnt <= '0;
    end else if (sample_edge) begin
      bit_cnt <= bit_cnt + 3'd1;
      rx_sh   <= {rx_sh[5:0], mosi_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_sh <= 8'hFF;
    else if (tx_take)    tx_sh <= tx_byte;
    else if (shift_edge) tx_sh <= {tx_sh[6:0], 1'b0};
  end

  a_r10_take_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (bit_cnt == 3'd0));
  a_r11_stop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    cs_stop |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/spi_target_fifo.sv
module spi_target_fifo
  import spit_pkg::*;
#(
  parameter int         AW          = 10,
  parameter int         THRESH_RST  = 8,
  parameter logic [7:0] IDLE_RST    = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [AW+1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rx_irq
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int CELLS = 2 * DEPTH;

  // Storage: lower half receive, upper half transmit.
  logic [7:0] mem [CELLS];

  spi_cfg_t      cfg;
  logic [PW-1:0] thresh;
  logic          ovf_q;

  logic [PW-1:0] rx_wr, rx_rd, rx_level;
  logic [PW-1:0] tx_wr, tx_rd;
  logic [PW-1:0] tx_level_unused;
  logic          rx_empty, rx_full, tx_empty, tx_full_unused;

  logic          tx_take, rx_done, cs_stop;
  logic [7:0]    rx_data, tx_next;
  logic          rx_push, tx_pop, ovf_set;

  logic          in_mem, mem_half, reg_wr, cpu_mem_wr;
  reg_sel_e      sel;
  logic [AW-2:0] word_idx;
  logic          unused_addr_lsbs;

  assign in_mem     = bus_addr[AW+1];
  assign mem_half   = bus_addr[AW];
  assign word_idx   = bus_addr[AW:2];
  assign sel        = reg_sel_e'(bus_addr[4:2]);
  assign reg_wr     = bus_wr & ~in_mem;
  assign cpu_mem_wr = bus_wr & in_mem & mem_half & (bus_be == 4'hF);
  assign unused_addr_lsbs = ^bus_addr[1:0];

  // Serial engine
  spit_engine #(.SYNC_STAGES(SYNC_STAGES)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (spi_sclk),
    .cs_n_i (spi_cs_n),
    .mosi_i (spi_mosi),
    .cpol   (cfg.cpol),
    .cpha   (cfg.cpha),
    .tx_byte(tx_next),
    .tx_take(tx_take),
    .rx_done(rx_done),
    .rx_data(rx_data),
    .cs_stop(cs_stop),
    .miso   (spi_miso)
  );

  assign rx_push = rx_done & ~rx_full;
  assign ovf_set = rx_done & rx_full;
  assign tx_pop  = tx_take & ~tx_empty;
  assign tx_next = tx_empty ? cfg.idle : mem[{1'b1, tx_rd[AW-1:0]}];

  // Pointer pairs
  spit_ptrs #(.AW(AW), .HW_WRITES(1'b1)) u_rxp (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_adv (rx_push),
    .sw_load(reg_wr && sel == SEL_RXRD),
    .sw_val (bus_wdata[PW-1:0]),
    .flush  (1'b0),
    .wr_ptr (rx_wr),
    .rd_ptr (rx_rd),
    .empty  (rx_empty),
    .full   (rx_full),
    .level  (rx_level)
  );

  spit_ptrs #(.AW(AW), .HW_WRITES(1'b0)) u_txp (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_adv (tx_pop),
    .sw_load(reg_wr && sel == SEL_TXWR),
    .sw_val (bus_wdata[PW-1:0]),
    .flush  (cs_stop),
    .wr_ptr (tx_wr),
    .rd_ptr (tx_rd),
    .empty  (tx_empty),
    .full   (tx_full_unused),
    .level  (tx_level_unused)
  );

  // Storage writes: serial side into the receive half, bus side into the transmit half.
  always_ff @(posedge clk) begin
    if (rx_push) mem[{1'b0, rx_wr[AW-1:0]}] <= rx_data;
    if (cpu_mem_wr) begin
      for (int k = 0; k < 4; k++)
        mem[{1'b1, bus_addr[AW-1:2], 2'(k)}] <= lane_of(bus_wdata, k);
    end
  end

  // Configuration and status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{idle: IDLE_RST, cpha: 1'b0, cpol: 1'b0};
      thresh <= PW'(THRESH_RST);
      ovf_q  <= 1'b0;
    end else begin
      if (reg_wr && sel == SEL_CTRL) begin
        cfg.cpol <= bus_wdata[0];
        cfg.cpha <= bus_wdata[1];
        cfg.idle <= bus_wdata[15:8];
      end
      if (reg_wr && sel == SEL_THRESH) thresh <= bus_wdata[PW-1:0];
      if (ovf_set)                                      ovf_q <= 1'b1;
      else if (reg_wr && sel == SEL_STAT && bus_wdata[1]) ovf_q <= 1'b0;
    end
  end

  assign rx_irq = (rx_level > thresh);

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (in_mem) begin
      bus_rdata = {mem[{word_idx, 2'd3}], mem[{word_idx, 2'd2}],
                   mem[{word_idx, 2'd1}], mem[{word_idx, 2'd0}]};
    end else begin
      case (sel)
        SEL_CTRL:   bus_rdata = {16'h0, cfg.idle, 6'h0, cfg.cpha, cfg.cpol};
        SEL_THRESH: bus_rdata = 32'(thresh);
        SEL_RXRD:   bus_rdata = 32'(rx_rd);
        SEL_RXWR:   bus_rdata = 32'(rx_wr);
        SEL_TXWR:   bus_rdata = 32'(tx_wr);
        SEL_TXRD:   bus_rdata = 32'(tx_rd);
        SEL_STAT:   bus_rdata = {30'h0, ovf_q, rx_irq};
        default:    bus_rdata = '0;
      endcase
    end
  end

  a_r3_ovf_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_q);
  a_r3_full_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> $stable(rx_wr));
  a_r4_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !rx_empty);
  a_r6_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_empty) |=> (spi_miso == $past(cfg.idle[7])));
endmodule

// File: tb/sim_spi_target_fifo.sv
`timescale 1ns/1ps
module sim_spi_target_fifo;
  localparam int AW   = 4;
  localparam int HALF = 32;
  localparam logic [5:0] A_CTRL = 6'h00, A_THR = 6'h04, A_RXRD = 6'h08, A_RXWR = 6'h0C,
                         A_TXWR = 6'h10, A_TXRD = 6'h14, A_STAT = 6'h18,
                         A_RXM = 6'h20, A_TXM = 6'h30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  wire  miso;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         rx_irq;
  logic cpol = 1'b0, cpha = 1'b0;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  spi_target_fifo #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_irq(rx_irq));

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rx_byte_at(input int idx, output logic [7:0] b);
    logic [31:0] w;
    brd(A_RXM + 6'((idx % 16) / 4 * 4), w);
    b = w[(idx % 4) * 8 +: 8];
  endtask

  task automatic rx_drain;
    logic [31:0] w;
    brd(A_RXWR, w);
    bwr(A_RXRD, w, 4'hF);
  endtask

  task automatic spi_begin;
    @(negedge clk); cs_n = 1'b0; #(HALF);
  endtask

  task automatic spi_end;
    #(HALF); cs_n = 1'b1; #(4*HALF);
  endtask

  task automatic spi_byte(input logic [7:0] d, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = d[i]; #(HALF); got[i] = miso; sclk = ~cpol; #(HALF); sclk = cpol;
      end else begin
        sclk = ~cpol; mosi = d[i]; #(HALF); got[i] = miso; sclk = cpol; #(HALF);
      end
    end
  endtask

  task automatic set_mode(input logic pol, input logic pha, input logic [7:0] idle);
    bwr(A_CTRL, {16'h0, idle, 6'h0, pha, pol}, 4'hF);
    @(negedge clk); cpol = pol; cpha = pha; sclk = pol;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] w;
    brd(A_CTRL, w); check("R1", "ctrl", w, 32'h0000FF00);
    brd(A_THR,  w); check("R1", "threshold", w, 32'd8);
    brd(A_RXWR, w); check("R1", "rx wr ptr", w, 0);
    brd(A_TXRD, w); check("R1", "tx rd ptr", w, 0);
    brd(A_STAT, w); check("R1", "status", w, 0);
    check("R1", "irq", 32'(rx_irq), 0);
  endtask

  task automatic t_rx_basic;
    logic [31:0] w; logic [7:0] g;
    logic [7:0] pat [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    spi_begin;
    for (int i = 0; i < 4; i++) begin
      spi_byte(pat[i], 8, g);
      check("R6", "filler on empty tx", 32'(g), 32'hFF);
    end
    spi_end;
    brd(A_RXWR, w); check("R2", "rx wr ptr after 4", w, 4);
    brd(A_RXM, w);  check("R2", "rx word 0", w, 32'hD4C3B2A1);
    check("R4", "irq at level 4", 32'(rx_irq), 0);
  endtask

  task automatic t_threshold;
    logic [31:0] w; logic [7:0] g;
    spi_begin;
    for (int i = 1; i <= 4; i++) spi_byte(8'(i), 8, g);
    spi_end;
    check("R4", "irq at level 8 (not above 8)", 32'(rx_irq), 0);
    spi_begin; spi_byte(8'h05, 8, g); spi_end;
    check("R4", "irq at level 9", 32'(rx_irq), 1);
    brd(A_STAT, w); check("R4", "status irq bit", 32'(w[0]), 1);
    bwr(A_THR, 32'd12, 4'hF);
    check("R4", "irq after threshold 12", 32'(rx_irq), 0);
    bwr(A_RXRD, 32'd9, 4'hF);
    bwr(A_THR, 32'd0, 4'hF);
    check("R12", "irq with threshold 0 after release", 32'(rx_irq), 0);
    bwr(A_THR, 32'd8, 4'hF);
  endtask

  task automatic t_overflow;
    logic [31:0] w; logic [7:0] g;
    spi_begin;
    for (int i = 0; i < 16; i++) spi_byte(8'h10 + 8'(i), 8, g);
    spi_end;
    brd(A_RXWR, w); check("R8", "rx wr ptr at full", w, 32'd25);
    check("R4", "irq at full", 32'(rx_irq), 1);
    spi_begin; spi_byte(8'hEE, 8, g); spi_end;
    brd(A_RXWR, w); check("R3", "rx wr ptr holds on overflow", w, 32'd25);
    brd(A_STAT, w); check("R3", "overflow flag", 32'(w[1]), 1);
    brd(A_RXM, w);  check("R8", "wrapped rx word 0", w, 32'h1A191817);
    brd(A_RXM + 6'h08, w); check("R3", "oldest byte kept", w, 32'h1211101F);
    bwr(A_STAT, 32'h2, 4'hF);
    brd(A_STAT, w); check("R3", "overflow cleared", 32'(w[1]), 0);
    bwr(A_RXRD, 32'd25, 4'hF);
    check("R12", "irq after draining", 32'(rx_irq), 0);
  endtask

  task automatic t_tx;
    logic [31:0] w; logic [7:0] g;
    logic [7:0] exp [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hFF, 8'hFF};
    bwr(A_TXM, 32'h44332211, 4'hF);
    bwr(A_TXWR, 32'd4, 4'hF);
    spi_begin;
    for (int i = 0; i < 6; i++) begin
      spi_byte(8'h00, 8, g);
      check(i < 4 ? "R5" : "R6", "tx byte order", 32'(g), 32'(exp[i]));
    end
    spi_end;
    brd(A_TXRD, w); check("R5", "tx rd ptr", w, 32'd4);
    rx_drain;
  endtask

  task automatic t_partial_write;
    logic [31:0] w;
    bwr(A_TXM + 6'h04, 32'hA5A5A5A5, 4'hF);
    bwr(A_TXM + 6'h04, 32'h00000000, 4'h3);
    brd(A_TXM + 6'h04, w); check("R9", "partial write ignored", w, 32'hA5A5A5A5);
  endtask

  task automatic t_flush;
    logic [31:0] w; logic [7:0] g;
    bwr(A_TXM + 6'h04, 32'h88776655, 4'hF);
    bwr(A_TXWR, 32'd8, 4'hF);
    spi_begin; spi_byte(8'h00, 8, g); spi_end;
    check("R5", "first queued byte", 32'(g), 32'h55);
    brd(A_TXRD, w); check("R7", "tx rd ptr after release", w, 32'd8);
    spi_begin; spi_byte(8'h00, 8, g); spi_end;
    check("R7", "no leftover byte", 32'(g), 32'hFF);
    set_mode(1'b0, 1'b0, 8'h5A);
    spi_begin; spi_byte(8'h00, 8, g); spi_end;
    check("R6", "programmed filler", 32'(g), 32'h5A);
    rx_drain;
  endtask

  task automatic t_modes;
    logic [31:0] w, st; logic [7:0] g;
    int txp = 8;
    for (int m = 1; m <= 3; m++) begin
      set_mode(m[0], m[1], 8'h5A);
      bwr(A_TXM + 6'((txp % 16) / 4 * 4),
          {8'(m*16+4), 8'(m*16+3), 8'(m*16+2), 8'(m*16+1)}, 4'hF);
      bwr(A_TXWR, 32'((txp + 4) % 32), 4'hF);
      brd(A_RXWR, st);
      spi_begin;
      for (int i = 0; i < 4; i++) begin
        spi_byte(8'hC0 + 8'(m*4 + i), 8, g);
        check("R10", "tx data in mode", 32'(g), 32'(m*16 + 1 + i));
      end
      spi_end;
      brd(A_RXWR, w); check("R10", "rx count in mode", w, (st + 4) % 32);
      for (int i = 0; i < 4; i++) begin
        rx_byte_at(int'(st) + i, g);
        check("R10", "rx data in mode", 32'(g), 32'(8'hC0 + 8'(m*4 + i)));
      end
      rx_drain;
      txp = (txp + 4) % 32;
    end
  endtask

  task automatic t_partial_byte;
    logic [31:0] w, st; logic [7:0] g;
    brd(A_RXWR, st);
    spi_begin; spi_byte(8'hF0, 4, g); spi_end;
    brd(A_RXWR, w); check("R11", "partial byte dropped", w, st);
    spi_begin; spi_byte(8'h96, 8, g); spi_end;
    brd(A_RXWR, w); check("R11", "next byte counted", w, (st + 1) % 32);
    rx_byte_at(int'(st), g);
    check("R11", "next byte aligned", 32'(g), 32'h96);
  endtask

  initial begin
    #200_000;
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_rx_basic;
    t_threshold;
    t_overflow;
    t_tx;
    t_partial_write;
    t_flush;
    t_modes;
    t_partial_byte;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule